// File: doc/BRIEF.md
# Command-Length-Aware Two-Wire Slave

This block is the serial front end of a small peripheral core. It sits on an I2C bus as a slave at one fixed seven-bit address. It receives write commands of one or two bytes and answers every read with a single status byte. The core sees each completed write as a one-cycle strobe that carries the opcode, an optional data byte and a length flag. The core returns a ready flag, and that flag appears in the status byte.

SCL and SDA arrive oversampled by the system clock. Each line passes through a synchronizer and a glitch filter before start, stop and edge detection. SDA is driven through an open-drain enable: `sda_oe` high means the line is pulled low.

The controller is a state machine with seven named states:
- `ST_IDLE`: ignores the bus.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_RX`: shifts in a command byte.
- `ST_RX_ACK`: drives the command-byte acknowledge.
- `ST_TX`: shifts out the status byte.
- `ST_TX_ACK`: samples the master's acknowledge.

Transitions:
- Start, from any state, goes to `ST_ADDR`. Stop, from any state, goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match, or to `ST_IDLE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_TX` for a read, or to `ST_RX` for a write.
- `ST_RX` goes to `ST_RX_ACK`.
- `ST_RX_ACK` returns to `ST_RX` when a second byte is due, or goes to `ST_IDLE` with the strobe.
- `ST_TX` goes to `ST_TX_ACK`, and `ST_TX_ACK` goes to `ST_IDLE`.

Top module: `cmd_i2c_slave`

## Requirements
- R1: After reset `sda_oe` and `cmd_valid` are 0. Outside a transaction, bytes clocked without a preceding start are never acknowledged.
- R2: After a start, the block takes 7 address bits MSB first, followed by a direction bit (1 = read, 0 = write). It holds `sda_oe` high through the ninth clock only when the address equals `SLAVE_ADDR`. Otherwise it stays released until the next start.
- R3: The block samples SDA on filtered SCL rising edges. It changes `sda_oe` only after a filtered SCL falling edge, a start or a stop. All bytes travel MSB first.
- R4: A first command byte with bit 7 set announces a two-byte command. Any other first byte is a one-byte command. Every expected byte is acknowledged.
- R5: Once a command is complete the block goes idle, and any further bytes in that transfer get no acknowledge and no strobe.
- R6: A stop aborts the transaction in progress. No command is issued and SDA is released.
- R7: A repeated start drops a partly received command and opens a new address phase, so commands can be chained without stops.
- R8: `cmd_valid` pulses for one cycle after the acknowledge of the command's last byte. The pulse carries `cmd_opcode`, `cmd_data` (second byte, or 0 for one-byte commands) and `cmd_two_byte` (equal to opcode bit 7). A two-byte command is never issued after its first byte alone.
- R9: A read returns the status byte right after the address acknowledge. Bit 7 is `core_ready`, bit 6 is the overrun flag, and bits 5..0 are 0.
- R10: A command issued while `core_ready` is 0 is still acknowledged and strobed, and it sets the overrun flag. Loading the status byte for a read clears the flag.
- R11: After the status byte the block releases SDA, takes the master's acknowledge bit, and goes idle whether that bit was ACK or NACK. Further read bits return 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| core_ready | input | 1 | Core can accept a new command |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_opcode | output | 8 | First command byte |
| cmd_data | output | 8 | Second command byte, 0 for one-byte commands |
| cmd_two_byte | output | 1 | Command carried a data byte |

## Verification
The hardest situation to reach is a repeated start that lands between the first and second byte of a two-byte command. It must leave no trace: no strobe, and no stale opcode in the next command. The bench builds this with a bit-level master model. That model can raise SDA while SCL is low and then issue the start edge without a stop, and it then chains two further commands the same way. Around this, the bench sweeps all 128 addresses and a stride of opcodes across both length classes. Each command is followed by an extra byte that must be refused.

// File: rtl/cis_pkg.sv
package cis_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } cis_state_e;
endpackage

// File: rtl/cis_line_filter.sv
module cis_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            if (sync_q[SYNC_STAGES-1] == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                dout  <= sync_q[SYNC_STAGES-1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cis_bus_events.sv
module cis_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
    assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/cis_protocol.sv
module cis_protocol
    import cis_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              sda_s,
    input  logic              core_ready,
    output logic              sda_oe,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_opcode,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_two_byte
);
    cis_state_e            state_q, state_d;
    logic [BITCNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]     shreg;
    logic [BYTE_W-1:0]     op_q;
    logic                  second_q;
    logic                  overrun_q;
    logic [BYTE_W-1:0]     status_w;
    logic                  byte_done;
    logic                  addr_hit;
    logic                  need_more;

    assign status_w  = {core_ready, overrun_q, {(BYTE_W-2){1'b0}}};
    assign byte_done = scl_fall && (bit_cnt == BITCNT_W'(BYTE_W));
    assign addr_hit  = (shreg[BYTE_W-1:1] == SLAVE_ADDR);
    assign need_more = !second_q && op_q[BYTE_W-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = ST_IDLE;
            ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
            ST_ADDR_ACK: if (scl_fall)  state_d = shreg[0] ? ST_TX : ST_RX;
            ST_RX:       if (byte_done) state_d = ST_RX_ACK;
            ST_RX_ACK:   if (scl_fall)  state_d = need_more ? ST_RX : ST_IDLE;
            ST_TX:       if (byte_done) state_d = ST_TX_ACK;
            ST_TX_ACK:   if (scl_rise)  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (bus_start)     state_d = ST_ADDR;
        else if (bus_stop) state_d = ST_IDLE;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            shreg        <= '0;
            op_q         <= '0;
            second_q     <= 1'b0;
            overrun_q    <= 1'b0;
            sda_oe       <= 1'b0;
            cmd_valid    <= 1'b0;
            cmd_opcode   <= '0;
            cmd_data     <= '0;
            cmd_two_byte <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (bus_start) begin
                bit_cnt  <= '0;
                second_q <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (bus_stop) begin
                sda_oe <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (byte_done) begin
                            if (state_q == ST_ADDR) begin
                                sda_oe <= addr_hit;
                            end else begin
                                sda_oe <= 1'b1;
                                if (!second_q) op_q <= shreg;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (shreg[0]) begin
                                shreg     <= status_w;
                                sda_oe    <= !status_w[BYTE_W-1];
                                overrun_q <= 1'b0;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            if (need_more) begin
                                second_q <= 1'b1;
                            end else begin
                                cmd_valid    <= 1'b1;
                                cmd_opcode   <= op_q;
                                cmd_data     <= second_q ? shreg : '0;
                                cmd_two_byte <= op_q[BYTE_W-1];
                                if (!core_ready) overrun_q <= 1'b1;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                        if (scl_fall) begin
                            if (bit_cnt == BITCNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= !shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK, ST_IDLE: sda_oe <= 1'b0;
                    default:            sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmd_i2c_slave.sv
module cmd_i2c_slave
    import cis_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h3A,
    parameter int                SYNC_STAGES = 2,
    parameter int                FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              core_ready,
    output logic              sda_oe,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_opcode,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_two_byte
);
    logic [1:0] line_raw;
    logic [1:0] line_f;
    logic       scl_f;
    logic       sda_f;
    logic       scl_rise;
    logic       scl_fall;
    logic       bus_start;
    logic       bus_stop;

    assign line_raw = {scl_in, sda_in};

    for (genvar gi = 0; gi < 2; gi++) begin : g_line
        cis_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[gi]),
            .dout (line_f[gi])
        );
    end

    assign scl_f = line_f[1];
    assign sda_f = line_f[0];

    cis_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    cis_protocol #(
        .SLAVE_ADDR(SLAVE_ADDR)
    ) u_proto (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .bus_start   (bus_start),
        .bus_stop    (bus_stop),
        .sda_s       (sda_f),
        .core_ready  (core_ready),
        .sda_oe      (sda_oe),
        .cmd_valid   (cmd_valid),
        .cmd_opcode  (cmd_opcode),
        .cmd_data    (cmd_data),
        .cmd_two_byte(cmd_two_byte)
    );
endmodule

// File: rtl/cis_checker.sv
module cis_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       cmd_valid,
    input logic [7:0] cmd_opcode,
    input logic [7:0] cmd_data,
    input logic       cmd_two_byte,
    input logic       scl_fall,
    input logic       bus_start,
    input logic       bus_stop
);
    assert_oe_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall || bus_start || bus_stop));

    assert_stop_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (!sda_oe && !cmd_valid));

    assert_start_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (!sda_oe && !cmd_valid));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_length_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_two_byte == cmd_opcode[7]));

    assert_short_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_two_byte) |-> (cmd_data == 8'h00));
endmodule

bind cmd_i2c_slave cis_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_oe      (sda_oe),
    .cmd_valid   (cmd_valid),
    .cmd_opcode  (cmd_opcode),
    .cmd_data    (cmd_data),
    .cmd_two_byte(cmd_two_byte),
    .scl_fall    (scl_fall),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop)
);

// File: tb/cmd_i2c_slave_test.sv
`timescale 1ns/1ps
module cmd_i2c_slave_test;
    localparam logic [6:0] SLV = 7'h3A;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic core_ready = 1'b1;
    logic sda_oe, cmd_valid, cmd_two_byte;
    logic [7:0] cmd_opcode, cmd_data;
    logic sda_bus;

    int n_checks = 0;
    int n_fail = 0;
    int n_cmd = 0;
    logic [7:0] last_op = '0;
    logic [7:0] last_data = '0;
    logic last_two = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    cmd_i2c_slave #(.SLAVE_ADDR(SLV)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .core_ready(core_ready), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
        .cmd_opcode(cmd_opcode), .cmd_data(cmd_data), .cmd_two_byte(cmd_two_byte)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            n_cmd++;
            last_op   = cmd_opcode;
            last_data = cmd_data;
            last_two  = cmd_two_byte;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
        wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus;
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic master_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!master_ack);
    endtask

    task automatic run_cmd(input logic [7:0] op);
        logic ack;
        logic [7:0] dat;
        int c0;
        dat = op ^ 8'hA5;
        c0 = n_cmd;
        bus_start();
        put_byte({SLV, 1'b0}, ack);
        check(ack, "R2 addr ack", ack, 1);
        put_byte(op, ack);
        check(ack, "R4 opcode ack", ack, 1);
        if (op[7]) begin
            check(n_cmd == c0, "R8 no early issue", n_cmd - c0, 0);
            put_byte(dat, ack);
            check(ack, "R4 data ack", ack, 1);
        end
        put_byte(8'h3C, ack);
        check(!ack, "R5 extra byte nack", ack, 0);
        bus_stop();
        check(n_cmd == c0 + 1, "R8 strobe count", n_cmd - c0, 1);
        check(last_op == op, "R8 opcode", last_op, op);
        check(last_data == (op[7] ? dat : 8'h00), "R8 data", last_data, op[7] ? dat : 8'h00);
        check(last_two == op[7], "R4 length flag", last_two, op[7]);
    endtask

    task automatic read_status(input logic [7:0] exp, input logic master_ack);
        logic ack;
        logic [7:0] v;
        bus_start();
        put_byte({SLV, 1'b1}, ack);
        check(ack, "R2 read addr ack", ack, 1);
        get_byte(v, master_ack);
        check(v == exp, "R9 R3 status byte", v, exp);
        get_byte(v, 1'b0);
        check(v == 8'hFF, "R11 released after status", v, 8'hFF);
        bus_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        int c0;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        check(cmd_valid == 1'b0, "R1 reset cmd_valid", cmd_valid, 0);
        rst_n = 1'b1;
        wq();

        // R1: bytes without start are ignored
        scl_m = 1'b0; wq();
        put_byte({SLV, 1'b0}, ack);
        check(!ack, "R1 no start no ack", ack, 0);
        bus_stop();

        // R2: address sweep
        c0 = n_cmd;
        for (int a = 0; a < 128; a++) begin
            bus_start();
            put_byte({a[6:0], 1'b0}, ack);
            check(ack == (a[6:0] == SLV), "R2 address match", ack, a[6:0] == SLV);
            bus_stop();
        end
        check(n_cmd == c0, "R6 no command from address only", n_cmd - c0, 0);

        // R4 R5 R8: opcode sweep across both lengths
        for (int k = 0; k < 256; k += 7) run_cmd(k[7:0]);
        run_cmd(8'h7F);
        run_cmd(8'h80);
        run_cmd(8'hFF);

        // R6: stop in the middle of a two-byte command
        c0 = n_cmd;
        bus_start();
        put_byte({SLV, 1'b0}, ack);
        put_byte(8'h85, ack);
        check(ack, "R6 first byte ack", ack, 1);
        bus_stop();
        check(n_cmd == c0, "R6 stop aborts", n_cmd - c0, 0);

        // R7: repeated start drops partial command, then chained commands
        c0 = n_cmd;
        bus_start();
        put_byte({SLV, 1'b0}, ack);
        put_byte(8'h9A, ack);
        bus_rstart();
        put_byte({SLV, 1'b0}, ack);
        check(ack, "R7 readdress ack", ack, 1);
        put_byte(8'h21, ack);
        check(ack, "R7 new opcode ack", ack, 1);
        check(n_cmd == c0 + 1, "R7 single issue", n_cmd - c0, 1);
        check(last_op == 8'h21, "R7 opcode after restart", last_op, 8'h21);
        bus_rstart();
        put_byte({SLV, 1'b0}, ack);
        put_byte(8'hC4, ack);
        put_byte(8'h5E, ack);
        check(ack, "R7 chained data ack", ack, 1);
        bus_stop();
        check(n_cmd == c0 + 2, "R7 chained issue", n_cmd - c0, 2);
        check(last_data == 8'h5E, "R7 chained data", last_data, 8'h5E);

        // R9 R10 R11: status reads
        core_ready = 1'b1;
        read_status(8'h80, 1'b0);
        core_ready = 1'b0;
        read_status(8'h00, 1'b0);
        run_cmd(8'h12);
        read_status(8'h40, 1'b0);
        read_status(8'h00, 1'b0);
        core_ready = 1'b1;
        run_cmd(8'hB0);
        read_status(8'h80, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule